// File: doc/BRIEF.md
# Linked-Descriptor Scatter-Gather DMA Channel

This block is one DMA channel that moves data between a word-addressed memory and a 16-bit peripheral stream. It follows a chain of descriptors held in that same memory. Each descriptor names a buffer and a byte length, carries an end-of-list flag, and points to the next descriptor. Software loads the address of the first descriptor, selects a direction and issues a start command. The channel then fetches each descriptor and moves its buffer one 16-bit word at a time. It stops after the descriptor that carries the end-of-list flag, or after a fixed maximum number of descriptors. A reset command aborts any walk and returns the channel to idle. Software polls a busy flag to learn when the channel is free to be reprogrammed.

In the outbound direction, halfwords are read from memory and offered on a valid/ready transmit stream. In the inbound direction, halfwords taken from a valid/ready receive stream are written to memory using byte enables. The memory port is a request/grant interface with one read outstanding at a time. Read data comes back on a separate valid strobe in a later cycle.

Back-pressure rules: a raised request, transmit valid or receive valid holds its payload stable until the partner accepts it. A transfer happens on a clock edge where both sides of a pair are high: `mem_req` with `mem_gnt`, `tx_valid` with `tx_ready`, or `rx_valid` with `rx_ready`. The channel never generates combinational paths from inputs to these outputs.

Top module: `ldma_channel`

## Requirements
- R1: A start command given while idle raises `busy` on the next cycle. The walk then reads the first descriptor at the pointer held in the first-descriptor register. That register takes `ptr_wr_data` on any cycle where `ptr_wr_en` is high. A descriptor is four 32-bit words: byte offset +0 holds the length in its low LEN_W bits, +4 holds the control word with end-of-list at bit 0, +8 holds the buffer byte address, and +12 holds the next-descriptor pointer.
- R2: With `dir_rx`=0 at start, buffer halfwords are read in ascending address order and sent on the transmit stream. The halfword at a byte address with bit 1 clear is bits 15:0 of the memory word; otherwise it is bits 31:16.
- R3: With `dir_rx`=1 at start, each received halfword is written to the next ascending buffer halfword. The write carries byte enables 0011 when address bit 1 is clear and 1100 when it is set, and the halfword is replicated on both halves of `mem_wdata`.
- R4: A length field of zero means 2^LEN_W bytes.
- R5: A length that is not zero moves ceil(length/2) halfwords, so an odd length is rounded up to a whole halfword, and nothing past that last halfword is touched.
- R6: After each descriptor the channel follows the next pointer. It stops, dropping `busy`, once it has completed a descriptor whose end-of-list bit is set; the next pointer of that descriptor is not fetched.
- R7: One start processes at most MAX_DESC descriptors, even if none of them carries end-of-list.
- R8: A start command given while busy has no effect on the walk in progress.
- R9: A reset command drops `busy` on the next cycle, along with every memory request and stream handshake. It wins over a start given in the same cycle, and the channel can be started again afterwards.
- R10: `mem_req`, `mem_addr`, `mem_we` and the transmit payload stay stable while waiting for grant or ready, and the data is correct under any pattern of grant, ready and valid stalls.
- R11: While idle the channel raises no `mem_req`, no `tx_valid` and no `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr_en | input | 1 | Load the first-descriptor register |
| ptr_wr_data | input | 32 | First-descriptor byte address |
| dir_rx | input | 1 | Direction sampled at start: 0 memory to stream, 1 stream to memory |
| cmd_go | input | 1 | Start command pulse |
| cmd_abort | input | 1 | Reset command pulse |
| busy | output | 1 | Channel is walking a list |
| mem_req | output | 1 | Memory request valid |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Transmit halfword valid |
| tx_ready | input | 1 | Peripheral takes the halfword |
| tx_data | output | 16 | Transmit halfword |
| rx_valid | input | 1 | Receive halfword valid |
| rx_ready | output | 1 | Channel takes the halfword |
| rx_data | input | 16 | Receive halfword |

## Verification
Directed lists test specific cases. One buffer starts on an odd halfword, to check which half of the word is used. Odd lengths test rounding, and a zero length tests the wrap value. A chain longer than the maximum with no end-of-list flag tests the descriptor cap. Each end-of-list descriptor points at a further valid descriptor, so any overrun shows up as extra stream words or extra memory writes. Random multi-descriptor lists in both directions run under random grant, ready and valid stalls; these show whether handshake holding and descriptor hand-over lose, repeat or reorder halfwords. Starts issued mid-walk, and resets issued mid-walk or together with a start, show whether the command priorities hold.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

  localparam int WORD_W   = 32;
  localparam int HALF_W   = 16;
  localparam int DESC_WORDS = 4;
  localparam int EOL_BIT  = 0;

  typedef struct packed {
    logic [WORD_W-1:0] len_raw;
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] buf_addr;
    logic [WORD_W-1:0] next_ptr;
  } ldma_desc_t;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_FETCH = 2'd1,
    CH_MOVE  = 2'd2
  } ch_state_e;

  typedef enum logic [1:0] {
    FT_IDLE = 2'd0,
    FT_REQ  = 2'd1,
    FT_WAIT = 2'd2
  } ft_state_e;

  typedef enum logic [2:0] {
    MV_IDLE    = 3'd0,
    MV_RD_REQ  = 3'd1,
    MV_RD_WAIT = 3'd2,
    MV_TX      = 3'd3,
    MV_RX      = 3'd4,
    MV_WR_REQ  = 3'd5
  } mv_state_e;

endpackage

// File: rtl/ldma_desc_fetch.sv
module ldma_desc_fetch
  import ldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              go,
  input  logic [WORD_W-1:0] base_addr,
  output logic              done,
  output ldma_desc_t        desc,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata
);

  localparam int IDX_W = $clog2(DESC_WORDS);

  ft_state_e         st;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word_q [DESC_WORDS];

  assign mem_req  = (st == FT_REQ);
  assign mem_addr = base_addr + {{(WORD_W-IDX_W-2){1'b0}}, idx, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= FT_IDLE;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st <= FT_IDLE;
      end else begin
        case (st)
          FT_IDLE: if (go) begin
            idx <= '0;
            st  <= FT_REQ;
          end
          FT_REQ: if (mem_gnt) st <= FT_WAIT;
          FT_WAIT: if (mem_rvalid) begin
            if (idx == IDX_W'(DESC_WORDS-1)) begin
              st   <= FT_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              st  <= FT_REQ;
            end
          end
          default: st <= FT_IDLE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[g] <= '0;
      else if (st == FT_WAIT && mem_rvalid && idx == IDX_W'(g)) word_q[g] <= mem_rdata;
    end
  end

  assign desc.len_raw  = word_q[0];
  assign desc.ctrl     = word_q[1];
  assign desc.buf_addr = word_q[2];
  assign desc.next_ptr = word_q[3];

  AST_FETCH_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || abort)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R10

endmodule

// File: rtl/ldma_data_mover.sv
module ldma_data_mover
  import ldma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              go,
  input  logic              dir_rx,
  input  logic [WORD_W-1:0] buf_addr,
  input  logic [LEN_W-1:0]  len,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [HALF_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [HALF_W-1:0] rx_data
);

  localparam int REM_W = LEN_W + 1;
  localparam logic [REM_W-1:0] FULL_LEN = REM_W'(1) << LEN_W;

  mv_state_e         st;
  logic [REM_W-1:0]  remain;
  logic [WORD_W-1:0] addr;
  logic [HALF_W-1:0] half_q;
  logic              rx_mode;
  logic              step;
  logic              last;
  logic [HALF_W-1:0] rd_half;

  assign mem_req   = (st == MV_RD_REQ) || (st == MV_WR_REQ);
  assign mem_we    = (st == MV_WR_REQ);
  assign mem_addr  = {addr[WORD_W-1:2], 2'b00};
  assign mem_be    = addr[1] ? 4'b1100 : 4'b0011;
  assign mem_wdata = {half_q, half_q};
  assign tx_valid  = (st == MV_TX);
  assign tx_data   = half_q;
  assign rx_ready  = (st == MV_RX);
  assign rd_half   = addr[1] ? mem_rdata[WORD_W-1:HALF_W] : mem_rdata[HALF_W-1:0];

  assign step = ((st == MV_TX) && tx_ready) || ((st == MV_WR_REQ) && mem_gnt);
  assign last = (remain <= REM_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= MV_IDLE;
      remain  <= '0;
      addr    <= '0;
      half_q  <= '0;
      rx_mode <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st     <= MV_IDLE;
        remain <= '0;
      end else if (st == MV_IDLE) begin
        if (go) begin
          remain  <= (len == '0) ? FULL_LEN : {1'b0, len};
          addr    <= buf_addr;
          rx_mode <= dir_rx;
          st      <= dir_rx ? MV_RX : MV_RD_REQ;
        end
      end else if (step) begin
        if (last) begin
          st     <= MV_IDLE;
          remain <= '0;
          done   <= 1'b1;
        end else begin
          remain <= remain - REM_W'(2);
          addr   <= addr + WORD_W'(2);
          st     <= rx_mode ? MV_RX : MV_RD_REQ;
        end
      end else begin
        case (st)
          MV_RD_REQ:  if (mem_gnt) st <= MV_RD_WAIT;
          MV_RD_WAIT: if (mem_rvalid) begin
            half_q <= rd_half;
            st     <= MV_TX;
          end
          MV_RX: if (rx_valid) begin
            half_q <= rx_data;
            st     <= MV_WR_REQ;
          end
          default: ;
        endcase
      end
    end
  end

  logic unused_addr_bit;
  assign unused_addr_bit = addr[0];

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || abort)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R10
  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || abort)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
  AST_ACTIVE_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (st != MV_IDLE) |-> (remain != '0)); // R5
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, rx_ready, mem_we})); // R3

endmodule

// File: rtl/ldma_mem_mux.sv
module ldma_mem_mux
  import ldma_pkg::*;
(
  input  logic              sel_fetch,
  input  logic              f_req,
  input  logic [WORD_W-1:0] f_addr,
  output logic              f_gnt,
  input  logic              m_req,
  input  logic              m_we,
  input  logic [WORD_W-1:0] m_addr,
  input  logic [3:0]        m_be,
  input  logic [WORD_W-1:0] m_wdata,
  output logic              m_gnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt
);

  always_comb begin
    if (sel_fetch) begin
      mem_req   = f_req;
      mem_we    = 1'b0;
      mem_addr  = f_addr;
      mem_be    = 4'b1111;
      mem_wdata = '0;
    end else begin
      mem_req   = m_req;
      mem_we    = m_we;
      mem_addr  = m_addr;
      mem_be    = m_be;
      mem_wdata = m_wdata;
    end
  end

  assign f_gnt = sel_fetch && mem_gnt;
  assign m_gnt = !sel_fetch && mem_gnt;

endmodule

// File: rtl/ldma_channel.sv
module ldma_channel
  import ldma_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MAX_DESC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ptr_wr_en,
  input  logic [31:0] ptr_wr_data,
  input  logic        dir_rx,
  input  logic        cmd_go,
  input  logic        cmd_abort,
  output logic        busy,
  output logic        mem_req,
  input  logic        mem_gnt,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [15:0] tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [15:0] rx_data
);

  localparam int CNT_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_DESC - 1);

  ch_state_e         state;
  logic [31:0]       first_q;
  logic [31:0]       cur_ptr;
  logic [CNT_W-1:0]  desc_cnt;
  logic              dir_q;
  logic              fetch_go;
  logic              move_go;
  logic              f_done;
  logic              m_done;
  ldma_desc_t        desc;

  logic              f_req, f_gnt, m_req, m_we, m_gnt;
  logic [31:0]       f_addr, m_addr, m_wdata;
  logic [3:0]        m_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CH_IDLE;
      first_q  <= '0;
      cur_ptr  <= '0;
      desc_cnt <= '0;
      dir_q    <= 1'b0;
      fetch_go <= 1'b0;
      move_go  <= 1'b0;
    end else begin
      fetch_go <= 1'b0;
      move_go  <= 1'b0;
      if (ptr_wr_en) first_q <= ptr_wr_data;
      if (cmd_abort) begin
        state <= CH_IDLE;
      end else begin
        case (state)
          CH_IDLE: if (cmd_go) begin
            cur_ptr  <= first_q;
            desc_cnt <= '0;
            dir_q    <= dir_rx;
            fetch_go <= 1'b1;
            state    <= CH_FETCH;
          end
          CH_FETCH: if (f_done) begin
            move_go <= 1'b1;
            state   <= CH_MOVE;
          end
          CH_MOVE: if (m_done) begin
            if (desc.ctrl[EOL_BIT] || desc_cnt == LAST_IDX) begin
              state <= CH_IDLE;
            end else begin
              cur_ptr  <= desc.next_ptr;
              desc_cnt <= desc_cnt + 1'b1;
              fetch_go <= 1'b1;
              state    <= CH_FETCH;
            end
          end
          default: state <= CH_IDLE;
        endcase
      end
    end
  end

  assign busy = (state != CH_IDLE);

  ldma_desc_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (cmd_abort),
    .go         (fetch_go),
    .base_addr  (cur_ptr),
    .done       (f_done),
    .desc       (desc),
    .mem_req    (f_req),
    .mem_addr   (f_addr),
    .mem_gnt    (f_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
  );

  ldma_data_mover #(.LEN_W(LEN_W)) u_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (cmd_abort),
    .go         (move_go),
    .dir_rx     (dir_q),
    .buf_addr   (desc.buf_addr),
    .len        (desc.len_raw[LEN_W-1:0]),
    .done       (m_done),
    .mem_req    (m_req),
    .mem_we     (m_we),
    .mem_addr   (m_addr),
    .mem_be     (m_be),
    .mem_wdata  (m_wdata),
    .mem_gnt    (m_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data)
  );

  ldma_mem_mux u_mux (
    .sel_fetch (state == CH_FETCH),
    .f_req     (f_req),
    .f_addr    (f_addr),
    .f_gnt     (f_gnt),
    .m_req     (m_req),
    .m_we      (m_we),
    .m_addr    (m_addr),
    .m_be      (m_be),
    .m_wdata   (m_wdata),
    .m_gnt     (m_gnt),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt)
  );

  logic unused_desc_bits;
  assign unused_desc_bits = ^{desc.ctrl[31:1], desc.len_raw};

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_go && !cmd_abort |=> busy); // R1
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_go && !cmd_abort && !m_done |=> busy && $stable(desc_cnt)); // R8
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !busy && !mem_req && !tx_valid && !rx_ready); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !tx_valid && !rx_ready); // R11
  AST_EOL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    state == CH_MOVE && m_done && desc.ctrl[EOL_BIT] && !cmd_abort |=> !busy); // R6

endmodule

// File: tb/ldma_channel_bench.sv
module ldma_channel_bench;

  localparam int LW   = 10;
  localparam int MD   = 64;
  localparam int MEMW = 2048;

  logic        clk, rst_n;
  logic        ptr_wr_en, dir_rx, cmd_go, cmd_abort, busy;
  logic [31:0] ptr_wr_data;
  logic        mem_req, mem_gnt, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic [15:0] tx_data, rx_data;

  ldma_channel #(.LEN_W(LW), .MAX_DESC(MD)) u_ldma_channel (
    .clk(clk), .rst_n(rst_n), .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
    .dir_rx(dir_rx), .cmd_go(cmd_go), .cmd_abort(cmd_abort), .busy(busy),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [MEMW];
  logic [15:0] rx_src [1100];
  int          rx_src_n = 0, rx_src_idx = 0;
  logic        rx_taken = 1'b0, rd_pend = 1'b0, bp_on = 1'b0, arm_first = 1'b0;
  logic [10:0] rd_idx = '0;
  logic [31:0] first_seen = '0;
  logic [15:0] got_q[$];
  logic [15:0] exp_q[$];

  // memory and stream partner model; values set here are seen at the next rising edge
  always @(negedge clk) begin
    cyc++;
    mem_rvalid = rd_pend;
    mem_rdata  = rd_pend ? mem[rd_idx] : 32'h0;
    rd_pend    = 1'b0;
    mem_gnt    = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
    if (mem_req && arm_first) begin
      first_seen = mem_addr;
      arm_first  = 1'b0;
    end
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[12:2]][8*b +: 8] = mem_wdata[8*b +: 8];
      end else begin
        rd_pend = 1'b1;
        rd_idx  = mem_addr[12:2];
      end
    end
    tx_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    if (tx_valid && tx_ready) got_q.push_back(tx_data);
    if (rx_taken) begin rx_valid = 1'b0; rx_taken = 1'b0; end
    if (rx_valid && rx_src_idx >= rx_src_n) rx_valid = 1'b0;
    if (!rx_valid && rx_src_idx < rx_src_n && (!bp_on || $urandom_range(0, 2) != 0)) begin
      rx_valid = 1'b1;
      rx_data  = rx_src[rx_src_idx];
    end
    if (rx_valid && rx_ready) begin rx_taken = 1'b1; rx_src_idx++; end
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_half(input logic [31:0] a);
    return a[1] ? mem[a[12:2]][31:16] : mem[a[12:2]][15:0];
  endfunction

  task automatic wr_half(input logic [31:0] a, input logic [15:0] v);
    if (a[1]) mem[a[12:2]][31:16] = v; else mem[a[12:2]][15:0] = v;
  endtask

  task automatic put_desc(input logic [31:0] at, input int len, input bit eol,
                          input logic [31:0] bufa, input logic [31:0] nxt);
    mem[at[12:2]]     = 32'(len);
    mem[at[12:2] + 1] = {31'h0, eol};
    mem[at[12:2] + 2] = bufa;
    mem[at[12:2] + 3] = nxt;
  endtask

  // expected halfword sequence of a list, from the requirements (R4, R5, R6, R7)
  task automatic walk_list(input logic [31:0] ptr);
    logic [31:0] p = ptr;
    exp_q.delete();
    for (int d = 0; d < MD; d++) begin
      int len = int'(mem[p[12:2]][LW-1:0]);
      int n   = (len == 0) ? (1 << LW) : len;
      for (int k = 0; k < (n + 1) / 2; k++) exp_q.push_back(rd_half(mem[p[12:2] + 2] + 32'(2 * k)));
      if (mem[p[12:2] + 1][0]) break;
      p = mem[p[12:2] + 3];
    end
  endtask

  task automatic launch(input logic [31:0] ptr, input bit rx, input string tag);
    @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_data = ptr; dir_rx = rx;
    @(negedge clk);
    ptr_wr_en = 1'b0; cmd_go = 1'b1; arm_first = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
    chk(busy == 1'b1, {tag, " R1 busy after start"}, longint'(busy), 1);
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy && t < 40000) begin @(negedge clk); t++; end
    chk(!busy, {tag, " R6 channel returns idle"}, longint'(busy), 0);
    @(negedge clk);
    chk(!mem_req && !tx_valid && !rx_ready, {tag, " R11 idle outputs quiet"},
        longint'({mem_req, tx_valid, rx_ready}), 0);
  endtask

  task automatic run_tx(input logic [31:0] ptr, input string tag);
    int bad = -1;
    walk_list(ptr);
    got_q.delete();
    launch(ptr, 1'b0, tag);
    wait_idle(tag);
    chk(first_seen == ptr, {tag, " R1 first fetch address"}, longint'(first_seen), longint'(ptr));
    chk(got_q.size() == exp_q.size(), {tag, " R2 stream word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
    chk(bad < 0, {tag, " R2 stream data"}, (bad < 0) ? 0 : longint'(got_q[bad]),
        (bad < 0) ? 0 : longint'(exp_q[bad]));
  endtask

  task automatic run_rx(input logic [31:0] ptr, input string tag);
    int n, bad = -1;
    walk_list(ptr);
    n = exp_q.size();
    for (int i = 0; i < n + 4; i++) rx_src[i] = 16'($urandom);
    rx_src_idx = 0;
    rx_src_n   = n + 4;
    launch(ptr, 1'b1, tag);
    wait_idle(tag);
    chk(rx_src_idx == n, {tag, " R3 words taken from stream"}, rx_src_idx, n);
    rx_src_n = 0;
    walk_list(ptr);
    for (int i = 0; i < n; i++) if (bad < 0 && exp_q[i] != rx_src[i]) bad = i;
    chk(bad < 0, {tag, " R3 memory contents"}, (bad < 0) ? 0 : longint'(exp_q[bad]),
        (bad < 0) ? 0 : longint'(rx_src[bad]));
  endtask

  // random chain of nd descriptors; the end-of-list one points at a further valid one
  task automatic mk_list(input int nd, input bit fill);
    logic [31:0] b = 32'h0800 + 32'(2 * $urandom_range(0, 3));
    for (int d = 0; d < nd; d++) begin
      int len = $urandom_range(1, 40);
      if (fill) for (int k = 0; k < (len + 1) / 2 + 1; k++) wr_half(b + 32'(2 * k), 16'($urandom));
      put_desc(32'(16 * d), len, d == nd - 1, b, 32'(16 * (d + 1)));
      b = b + 32'(len + (len & 1) + 2 * $urandom_range(1, 3));
    end
    put_desc(32'(16 * nd), 4, 1'b1, 32'h1F00, 32'h0);
    mem[32'h1F00 >> 2] = 32'hDEAD_BEEF;
    mem[(32'h1F00 >> 2) + 1] = 32'hFACE_CAFE;
  endtask

  initial begin
    void'($urandom(32'd7717));
    rst_n = 1'b0; ptr_wr_en = 1'b0; ptr_wr_data = '0; dir_rx = 1'b0;
    cmd_go = 1'b0; cmd_abort = 1'b0; mem_gnt = 1'b1; mem_rvalid = 1'b0;
    mem_rdata = '0; tx_ready = 1'b1; rx_valid = 1'b0; rx_data = '0;
    for (int i = 0; i < MEMW; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !tx_valid && !rx_ready, "R11 reset state",
        longint'({busy, mem_req, tx_valid, rx_ready}), 0);

    // R2: single descriptor, buffer starting on an upper halfword
    put_desc(32'h0, 8, 1'b1, 32'h0802, 32'h10);
    put_desc(32'h10, 2, 1'b1, 32'h0900, 32'h0);
    run_tx(32'h0, "directed tx R2");

    // R3: inbound single descriptor
    put_desc(32'h40, 6, 1'b1, 32'h0A00, 32'h10);
    run_rx(32'h40, "directed rx R3");

    // R5: odd lengths round up, nothing beyond is touched
    put_desc(32'h80, 5, 1'b1, 32'h0B00, 32'h10);
    run_tx(32'h80, "odd tx R5");
    chk(exp_q.size() == 3, "R5 odd length 5 gives 3 halfwords", exp_q.size(), 3);
    wr_half(32'h0C04, 16'h5A5A);
    put_desc(32'hC0, 3, 1'b1, 32'h0C00, 32'h10);
    run_rx(32'hC0, "odd rx R5");
    chk(rd_half(32'h0C04) == 16'h5A5A, "R5 halfword past buffer untouched",
        longint'(rd_half(32'h0C04)), 16'h5A5A);

    // R4: zero length means 2^LW bytes
    bp_on = 1'b1;
    put_desc(32'h100, 0, 1'b1, 32'h0800, 32'h10);
    run_tx(32'h100, "zero length R4");
    chk(got_q.size() == (1 << (LW - 1)), "R4 zero length word count", got_q.size(), 1 << (LW - 1));

    // R7: chain longer than the cap with no end-of-list
    for (int d = 0; d < MD + 2; d++) begin
      put_desc(32'(16 * d), 2, 1'b0, 32'h0800 + 32'(2 * d), 32'(16 * (d + 1)));
      wr_half(32'h0800 + 32'(2 * d), 16'(16'h1000 + d));
    end
    run_tx(32'h0, "descriptor cap R7");
    chk(got_q.size() == MD, "R7 at most MAX_DESC descriptors", got_q.size(), MD);

    // R8: start while busy has no effect
    mk_list(3, 1'b1);
    put_desc(32'h600, 6, 1'b1, 32'h1F00, 32'h0);
    walk_list(32'h0);
    got_q.delete();
    launch(32'h0, 1'b0, "busy start R8");
    repeat (4) @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_data = 32'h600; cmd_go = 1'b1;
    @(negedge clk);
    ptr_wr_en = 1'b0; cmd_go = 1'b0;
    wait_idle("busy start R8");
    chk(got_q.size() == exp_q.size(), "R8 start while busy ignored, count", got_q.size(), exp_q.size());
    chk(got_q.size() > 0 && got_q[0] == exp_q[0], "R8 start while busy ignored, data",
        got_q.size() > 0 ? longint'(got_q[0]) : -1, longint'(exp_q[0]));

    // R9: reset mid-walk, reset together with start, then restart
    put_desc(32'h100, 0, 1'b1, 32'h0800, 32'h10);
    launch(32'h100, 1'b0, "abort R9");
    repeat (30) @(negedge clk);
    cmd_abort = 1'b1;
    @(negedge clk);
    cmd_abort = 1'b0;
    chk(!busy && !mem_req && !tx_valid && !rx_ready, "R9 abort to idle next cycle",
        longint'({busy, mem_req, tx_valid, rx_ready}), 0);
    repeat (3) @(negedge clk);
    cmd_abort = 1'b1; cmd_go = 1'b1;
    @(negedge clk);
    cmd_abort = 1'b0; cmd_go = 1'b0;
    chk(!busy, "R9 abort wins over start", longint'(busy), 0);
    mk_list(2, 1'b0);
    run_rx(32'h0, "restart after abort R9");

    // R6/R10: random chains in both directions under random stalls
    for (int t = 0; t < 8; t++) begin
      mk_list($urandom_range(1, 4), 1'b1);
      run_tx(32'h0, "random tx R6 R10");
      mk_list($urandom_range(1, 4), 1'b0);
      run_rx(32'h0, "random rx R6 R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule